// File: doc/BRIEF.md
# Paged Memory Map Decoder

This block sits between a 16-bit CPU address bus and the memories of a banked system. For every access it returns a region code, a bank index and a slot number that tell the memory fabric which store to enable. Reads and writes are decoded separately, because several mode flags affect only one direction. The outputs follow the address and mode inputs in the same cycle, with no register in the path.

The only state is a 3-bit register holding the slot that owns the shared expansion window at C800–CFFF. Any access to a slot page gives that slot the window. An access to CFFF hands the window back. Owner value zero means nobody holds the window, so expansion accesses fall through as unmapped.

Address decoding is priority ordered by ascending address limit: low RAM, I/O page, slot pages, expansion window, upper area. In the upper area, mode flags select between banked RAM (block-selectable, with two D-page banks) and one of four ROM pages. Unmapped reads return a fixed fill byte and unmapped writes are not strobed.

Top module: `mmap_decoder`

## Requirements
- R1: For addresses 0000–BFFF the region is 1 (main RAM), or 2 (alternate main RAM) when the alternate flag for the access direction (`alt_rd` for reads, `alt_wr` for writes) is set.
- R2: For addresses C000–C0FF the region is 3 (I/O page) for reads and writes alike.
- R3: For addresses C100–C7FF the region is 5 (slot ROM) and `slot_num` is address bits 10:8. A valid access there makes that slot the expansion owner: `exp_owner` shows it after the next rising clock edge.
- R4: For addresses C800–CFFF the region is 6 (expansion ROM) with `slot_num` equal to the current owner. When the owner is 0 the region is 0 (unmapped).
- R5: A valid access to CFFF is decoded against the owner held before it, then sets the owner to 0 at the clock edge.
- R6: For a read with `fw_all` set, all of C100–CFFF decodes as region 4 (internal firmware), and the owner is neither set nor cleared by that read.
- R7: For a read with `fw_slot3` set (and `fw_all` clear), page C3xx decodes as region 4 and leaves the owner unchanged. The other slot pages still decode as region 5.
- R8: Writes ignore `fw_all` and `fw_slot3`. Slot pages and the expansion window decode and update the owner as in R3–R5.
- R9: For D000–FFFF with the upper RAM enable of the access direction set (`hi_ram_rd` or `hi_ram_wr`), the region depends on the address range and on `hi_alt_d`. For D000–DFFF it is 7 (primary D bank) when `hi_alt_d` is clear and 8 (alternate D bank) when it is set. For E000–FFFF it is 9 (E/F RAM). In all three cases `bank_idx` equals `hi_block`.
- R10: For D000–FFFF with that enable clear, the region is 10 (ROM page) and `bank_idx` equals `rom_page`.
- R11: Region 0 has two effects on the access. A read drives `fill_byte` to F4; in every other case `fill_byte` is 00. `wr_en` is high only for a valid write to a region other than 0.
- R12: Reset sets the owner to 0. Non-slot regions drive `slot_num` 0, and regions other than 7–10 drive `bank_idx` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_wr | input | 1 | 1 for write, 0 for read |
| acc_addr | input | 16 | CPU address |
| alt_rd | input | 1 | Reads of low RAM use the alternate bank |
| alt_wr | input | 1 | Writes of low RAM use the alternate bank |
| fw_all | input | 1 | Reads of C100–CFFF use internal firmware |
| fw_slot3 | input | 1 | Reads of C3xx use internal firmware |
| hi_ram_rd | input | 1 | Upper-area reads go to RAM |
| hi_ram_wr | input | 1 | Upper-area writes go to RAM |
| hi_alt_d | input | 1 | Select the alternate D bank |
| hi_block | input | BLK_W | Upper RAM block number |
| rom_page | input | PAGE_W | Upper ROM page |
| region | output | 4 | Region code |
| bank_idx | output | BANK_W | Block or ROM page index |
| slot_num | output | 3 | Slot for regions 5 and 6 |
| exp_owner | output | 3 | Current expansion window owner |
| wr_en | output | 1 | Write strobe to a mapped region |
| fill_byte | output | 8 | Read fill value for unmapped reads |

## Verification
The bench targets the corner cases where a wrong decoder fails.

- **CFFF while a slot owns the window.** A design that cleared the owner first would report region 0 instead of the old owner.
- **Reads under `fw_all` at a slot page and at CFFF.** A design that let those reads take or release the window would show a changed `exp_owner` one edge later.
- **Writes with both override flags set.** A design that applied overrides to writes would report region 4 and fail to record the owner.
- **Range boundaries.** Addresses BFFF/C000, C0FF/C100, C7FF/C800 and DFFF/E000 catch off-by-one limits, and random traffic checks every direction-specific flag against an independent model.

// File: rtl/mmap_pkg.sv
package mmap_pkg;

    typedef enum logic [3:0] {
        RG_NONE     = 4'd0,
        RG_MAIN     = 4'd1,
        RG_MAIN_ALT = 4'd2,
        RG_IO       = 4'd3,
        RG_FW       = 4'd4,
        RG_SLOT     = 4'd5,
        RG_EXP      = 4'd6,
        RG_D        = 4'd7,
        RG_D_ALT    = 4'd8,
        RG_EF       = 4'd9,
        RG_ROMPG    = 4'd10
    } region_e;

    typedef enum logic [2:0] {
        Z_LOW   = 3'd0,
        Z_IO    = 3'd1,
        Z_SLOT  = 3'd2,
        Z_EXP   = 3'd3,
        Z_UPPER = 3'd4
    } zone_e;

    localparam logic [15:0] LIM_LOW  = 16'hBFFF;
    localparam logic [15:0] LIM_IO   = 16'hC0FF;
    localparam logic [15:0] LIM_SLOT = 16'hC7FF;
    localparam logic [15:0] LIM_EXP  = 16'hCFFF;
    localparam logic [15:0] LIM_D    = 16'hDFFF;
    localparam logic [15:0] REL_ADDR = 16'hCFFF;
    localparam logic [7:0]  FILL     = 8'hF4;
    localparam int          SLOT_W   = 3;

    typedef struct packed {
        logic [SLOT_W-1:0] owner;
    } own_state_t;

endpackage

// File: rtl/mmap_classify.sv
module mmap_classify
    import mmap_pkg::*;
(
    input  logic [15:0] addr,
    output zone_e       zone
);
    // Priority by ascending address limit.
    always_comb begin
        if (addr <= LIM_LOW)       zone = Z_LOW;
        else if (addr <= LIM_IO)   zone = Z_IO;
        else if (addr <= LIM_SLOT) zone = Z_SLOT;
        else if (addr <= LIM_EXP)  zone = Z_EXP;
        else                       zone = Z_UPPER;
    end
endmodule

// File: rtl/mmap_upper.sv
module mmap_upper
    import mmap_pkg::*;
#(
    parameter int BLK_W  = 3,
    parameter int PAGE_W = 2,
    parameter int BANK_W = 3
) (
    input  logic [15:0]       addr,
    input  logic              ram_on,
    input  logic              alt_d,
    input  logic [BLK_W-1:0]  block,
    input  logic [PAGE_W-1:0] page,
    output region_e           rg,
    output logic [BANK_W-1:0] bank
);
    always_comb begin
        if (ram_on) begin
            bank = BANK_W'(block);
            if (addr <= LIM_D) rg = alt_d ? RG_D_ALT : RG_D;
            else               rg = RG_EF;
        end else begin
            bank = BANK_W'(page);
            rg   = RG_ROMPG;
        end
    end
endmodule

// File: rtl/mmap_owner.sv
module mmap_owner
    import mmap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [SLOT_W-1:0] set_slot,
    input  logic              clr_en,
    output logic [SLOT_W-1:0] owner
);
    own_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_en)      st_d.owner = set_slot;
        else if (clr_en) st_d.owner = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign owner = st_q.owner;
endmodule

// File: rtl/mmap_decoder.sv
module mmap_decoder
    import mmap_pkg::*;
#(
    parameter int NUM_BLOCKS = 8,
    parameter int ROM_PAGES  = 4,
    localparam int BLK_W  = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
    localparam int PAGE_W = (ROM_PAGES > 1) ? $clog2(ROM_PAGES) : 1,
    localparam int BANK_W = (BLK_W > PAGE_W) ? BLK_W : PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_wr,
    input  logic [15:0]       acc_addr,
    input  logic              alt_rd,
    input  logic              alt_wr,
    input  logic              fw_all,
    input  logic              fw_slot3,
    input  logic              hi_ram_rd,
    input  logic              hi_ram_wr,
    input  logic              hi_alt_d,
    input  logic [BLK_W-1:0]  hi_block,
    input  logic [PAGE_W-1:0] rom_page,
    output logic [3:0]        region,
    output logic [BANK_W-1:0] bank_idx,
    output logic [2:0]        slot_num,
    output logic [2:0]        exp_owner,
    output logic              wr_en,
    output logic [7:0]        fill_byte
);
    zone_e             zone;
    region_e           up_rg, rg;
    logic [BANK_W-1:0] up_bk, bk;
    logic [SLOT_W-1:0] page_slot, sl, owner_q;
    logic              is_rd, own_set, own_clr;

    assign is_rd     = !acc_wr;
    assign page_slot = acc_addr[10:8];

    mmap_classify u_cls (.addr(acc_addr), .zone(zone));

    mmap_upper #(.BLK_W(BLK_W), .PAGE_W(PAGE_W), .BANK_W(BANK_W)) u_up (
        .addr   (acc_addr),
        .ram_on (acc_wr ? hi_ram_wr : hi_ram_rd),
        .alt_d  (hi_alt_d),
        .block  (hi_block),
        .page   (rom_page),
        .rg     (up_rg),
        .bank   (up_bk)
    );

    mmap_owner u_own (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (own_set),
        .set_slot (page_slot),
        .clr_en   (own_clr),
        .owner    (owner_q)
    );

    always_comb begin
        rg      = RG_NONE;
        sl      = '0;
        bk      = '0;
        own_set = 1'b0;
        own_clr = 1'b0;
        case (zone)
            Z_LOW:  rg = (acc_wr ? alt_wr : alt_rd) ? RG_MAIN_ALT : RG_MAIN;
            Z_IO:   rg = RG_IO;
            Z_SLOT: begin
                if (is_rd && (fw_all || (fw_slot3 && page_slot == 3'd3))) begin
                    rg = RG_FW;
                end else begin
                    rg      = RG_SLOT;
                    sl      = page_slot;
                    own_set = acc_valid;
                end
            end
            Z_EXP: begin
                if (is_rd && fw_all) begin
                    rg = RG_FW;
                end else begin
                    if (owner_q != '0) begin
                        rg = RG_EXP;
                        sl = owner_q;
                    end
                    own_clr = acc_valid && (acc_addr == REL_ADDR);
                end
            end
            Z_UPPER: begin
                rg = up_rg;
                bk = up_bk;
            end
            default: rg = RG_NONE;
        endcase
    end

    assign region    = rg;
    assign bank_idx  = bk;
    assign slot_num  = sl;
    assign exp_owner = owner_q;
    assign wr_en     = acc_valid && acc_wr && (rg != RG_NONE);
    assign fill_byte = (is_rd && rg == RG_NONE) ? FILL : 8'h00;
endmodule

// File: rtl/mmap_decoder_chk.sv
module mmap_decoder_chk #(
    parameter int PAGE_W = 2,
    parameter int BANK_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_wr,
    input logic [15:0]       acc_addr,
    input logic              alt_rd,
    input logic              fw_all,
    input logic              hi_ram_rd,
    input logic [PAGE_W-1:0] rom_page,
    input logic [3:0]        region,
    input logic [BANK_W-1:0] bank_idx,
    input logic [2:0]        exp_owner,
    input logic              wr_en,
    input logic [7:0]        fill_byte
);
    assert_low_main_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_wr && acc_addr <= 16'hBFFF && !alt_rd) |-> region == 4'd1);

    assert_io_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_addr[15:8] == 8'hC0) |-> region == 4'd3);

    assert_owner_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_wr && acc_addr >= 16'hC100 && acc_addr <= 16'hC7FF)
        |=> exp_owner == $past(acc_addr[10:8]));

    assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_wr && acc_addr == 16'hCFFF) |=> exp_owner == 3'd0);

    assert_fw_region_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_wr && fw_all && acc_addr >= 16'hC100 && acc_addr <= 16'hCFFF)
        |-> region == 4'd4);

    assert_fw_keeps_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_wr && fw_all && acc_addr >= 16'hC100 && acc_addr <= 16'hCFFF)
        |=> $stable(exp_owner));

    assert_rom_page_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_wr && acc_addr >= 16'hD000 && !hi_ram_rd)
        |-> (region == 4'd10 && bank_idx == BANK_W'(rom_page)));

    assert_fill_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_wr && region == 4'd0) |-> fill_byte == 8'hF4);

    assert_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (region == 4'd0) |-> !wr_en);
endmodule

bind mmap_decoder mmap_decoder_chk #(.PAGE_W(PAGE_W), .BANK_W(BANK_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_wr    (acc_wr),
    .acc_addr  (acc_addr),
    .alt_rd    (alt_rd),
    .fw_all    (fw_all),
    .hi_ram_rd (hi_ram_rd),
    .rom_page  (rom_page),
    .region    (region),
    .bank_idx  (bank_idx),
    .exp_owner (exp_owner),
    .wr_en     (wr_en),
    .fill_byte (fill_byte)
);

// File: tb/sim_mmap_decoder.sv
`timescale 1ns/1ps
module sim_mmap_decoder;
    localparam int BLK_W  = 3;
    localparam int PAGE_W = 2;
    localparam int BANK_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_valid = 0, acc_wr = 0;
    logic [15:0] acc_addr = '0;
    logic alt_rd = 0, alt_wr = 0, fw_all = 0, fw_slot3 = 0;
    logic hi_ram_rd = 0, hi_ram_wr = 0, hi_alt_d = 0;
    logic [BLK_W-1:0] hi_block = '0;
    logic [PAGE_W-1:0] rom_page = '0;
    logic [3:0] region;
    logic [BANK_W-1:0] bank_idx;
    logic [2:0] slot_num, exp_owner;
    logic wr_en;
    logic [7:0] fill_byte;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [2:0] m_owner = 3'd0;

    always #4 clk = ~clk;

    mmap_decoder u0 (.*);

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Independent reference model of the requirements.
    task automatic model(input logic wr, input logic [15:0] a, input logic [2:0] own,
                         output int rg, output int sl, output int bk,
                         output bit set, output bit clr);
        bit rd = !wr;
        rg = 0; sl = 0; bk = 0; set = 0; clr = 0;
        if (a < 16'hC000) rg = (wr ? alt_wr : alt_rd) ? 2 : 1;
        else if (a < 16'hC100) rg = 3;
        else if (a < 16'hC800) begin
            if (rd && (fw_all || (fw_slot3 && a[10:8] == 3))) rg = 4;
            else begin rg = 5; sl = a[10:8]; set = 1; end
        end else if (a < 16'hD000) begin
            if (rd && fw_all) rg = 4;
            else begin
                if (own != 0) begin rg = 6; sl = own; end
                clr = (a == 16'hCFFF);
            end
        end else if (wr ? hi_ram_wr : hi_ram_rd) begin
            bk = hi_block;
            rg = (a >= 16'hE000) ? 9 : (hi_alt_d ? 8 : 7);
        end else begin
            rg = 10; bk = rom_page;
        end
    endtask

    function automatic string tag_of(int rg, logic wr, logic [15:0] a);
        case (rg)
            0: return "R11";
            1, 2: return "R1";
            3: return "R2";
            4: return (!fw_all && a[11:8] == 4'h3) ? "R7" : "R6";
            5: return (wr && (fw_all || fw_slot3)) ? "R8" : "R3";
            6: return "R4";
            7, 8, 9: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic access(input logic v, input logic wr, input logic [15:0] a,
                          input string tag);
        int rg, sl, bk;
        bit set, clr;
        string t, ot;
        logic [2:0] nxt;
        @(negedge clk);
        acc_valid = v; acc_wr = wr; acc_addr = a;
        #1;
        model(wr, a, m_owner, rg, sl, bk, set, clr);
        t = (tag == "") ? tag_of(rg, wr, a) : tag;
        check(region == 4'(rg), t, "region", region, rg);
        check(slot_num == 3'(sl), (rg == 5 || rg == 6) ? t : "R12", "slot_num", slot_num, sl);
        check(bank_idx == BANK_W'(bk), (rg >= 7) ? t : "R12", "bank_idx", bank_idx, bk);
        check(fill_byte == ((!wr && rg == 0) ? 8'hF4 : 8'h00), "R11", "fill_byte",
              fill_byte, (!wr && rg == 0) ? 8'hF4 : 8'h00);
        check(wr_en == (v && wr && rg != 0), "R11", "wr_en", wr_en, int'(v && wr && rg != 0));
        nxt = m_owner;
        ot = "R3";
        if (v && set) nxt = a[10:8];
        else if (v && clr) begin nxt = 0; ot = "R5"; end
        else if (rg == 4) ot = (tag_of(rg, wr, a) == "R7") ? "R7" : "R6";
        @(posedge clk);
        m_owner = nxt;
        #1;
        check(exp_owner == m_owner, ot, "exp_owner", exp_owner, m_owner);
    endtask

    task automatic clear_flags();
        alt_rd = 0; alt_wr = 0; fw_all = 0; fw_slot3 = 0;
        hi_ram_rd = 0; hi_ram_wr = 0; hi_alt_d = 0; hi_block = 0; rom_page = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED_0042);
        repeat (3) @(posedge clk);
        #1;
        check(exp_owner == 3'd0, "R12", "owner after reset", exp_owner, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Directed corner cases
        clear_flags();
        access(1, 0, 16'hC800, "R4");          // owner 0: unmapped read
        access(1, 1, 16'hCABC, "R11");         // unmapped write dropped
        access(1, 0, 16'hBFFF, "R1");
        alt_wr = 1;
        access(1, 1, 16'h0000, "R1");
        access(1, 0, 16'hC000, "R2");
        access(1, 1, 16'hC0FF, "R2");
        access(1, 0, 16'hC2FF, "R3");          // owner becomes 2
        access(1, 0, 16'hC800, "R4");
        access(1, 0, 16'hCFFF, "R5");          // decodes slot 2, then clears
        access(1, 0, 16'hC810, "R4");
        access(1, 1, 16'hC7FF, "R3");          // owner 7
        fw_all = 1;
        access(1, 0, 16'hC500, "R6");
        access(1, 0, 16'hCFFF, "R6");          // must not clear
        fw_all = 0; fw_slot3 = 1;
        access(1, 0, 16'hC305, "R7");
        access(1, 0, 16'hC405, "R7");          // other slot unaffected
        fw_all = 1;
        access(1, 1, 16'hC300, "R8");          // write ignores overrides
        access(1, 1, 16'hC900, "R8");
        access(1, 1, 16'hCFFF, "R8");
        fw_all = 0; fw_slot3 = 0;
        hi_ram_rd = 1; hi_block = 3'd5; hi_alt_d = 1;
        access(1, 0, 16'hDFFF, "R9");
        access(1, 0, 16'hE000, "R9");
        access(1, 1, 16'hD000, "R10");         // write enable clear
        hi_ram_rd = 0; rom_page = 2'd3;
        access(1, 0, 16'hFFFC, "R10");
        access(0, 0, 16'hC600, "R3");          // no valid: owner holds

        // Constrained random
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] a;
            int sel = $urandom % 8;
            a = 16'($urandom);
            case (sel)
                0: a = {2'b00, a[13:0]};
                1: a = {8'hC0, a[7:0]};
                2: a = {5'b11000, a[10:0]} | 16'h0100;
                3: a = {5'b11001, a[10:0]};
                4: a = 16'hCFFF;
                5: a = {4'hD, a[11:0]};
                default: ;
            endcase
            alt_rd = 1'($urandom); alt_wr = 1'($urandom);
            fw_all = (($urandom % 4) == 0);
            fw_slot3 = 1'($urandom);
            hi_ram_rd = 1'($urandom); hi_ram_wr = 1'($urandom);
            hi_alt_d = 1'($urandom);
            hi_block = BLK_W'($urandom); rom_page = PAGE_W'($urandom);
            access((($urandom % 8) != 0), 1'($urandom), a, "");
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule